// File: doc/BRIEF.md
# Horizontal sync presence detector

This block watches a sliced video signal and decides whether a usable horizontal sync is there. It has two digital inputs. `tip_i` comes from an analog slicer and is high while the clamped signal sits below the slice level, so it is high during the sync tip. `amp_ok_i` comes from an amplitude comparator and is high when the sync was deep enough to count. All timing is measured in system clocks. A line runs from one rising edge of `tip_i` to the next. For each line the block counts the clocks spent outside sync and rates the line as good, middling, bad or invalid.

A three-state machine turns these ratings into one flag. The states are NOSYNC, LOCKED and HOLD.
- NOSYNC to LOCKED on a good line.
- LOCKED to HOLD on a loss event. A loss event is a bad line, an invalid line or a missed line. The hold count starts at 1.
- HOLD back to LOCKED on a good line. The hold count is cleared.
- HOLD to NOSYNC on the loss event that would bring the count to `HOLD_LINES`.
- Any other event leaves the state as it is.

A separate gap timer creates a missed-line event whenever 1.5 nominal lines pass with no edge. This lets a lost signal run out the hold on its own. The flag is high in LOCKED and HOLD. It is also presented as bit 5 of a status byte.

Top module: `sync_presence_det`

## Requirements
- R1: After reset `sync_flag_o` is 0 and `status_o` is 8'h00.
- R2: A line is good when it has a valid period, `amp_ok_i` was high at its opening edge, and its out-of-sync clock count times 100 is at least `HI_PCT` (91) times its period. A good line sets the flag from NOSYNC. The 91% boundary counts as good.
- R3: A line whose out-of-sync count times 100 is at most `LO_PCT` (84) times its period is bad. The 84% boundary counts as bad. A bad line is a loss event.
- R4: A line strictly between the two thresholds is middling. A middling line changes neither the flag nor the hold count, whether the flag is 0 or 1.
- R5: A line whose opening edge saw `amp_ok_i` low is invalid whatever its duty. It can never set the flag, and it is a loss event.
- R6: A line period below `LINE_CLKS/2` or above `2*LINE_CLKS` clocks is invalid. Both limits themselves are valid periods.
- R7: Once the flag is set, it stays 1 through `HOLD_LINES-1` (13) loss events in a row and drops to 0 on the next one. A good line during the hold restores LOCKED and clears the count.
- R8: With no rising edge on `tip_i`, a missed-line loss event occurs every `LINE_CLKS + LINE_CLKS/2` clocks. A lost signal therefore clears the flag after `HOLD_LINES` such periods.
- R9: `status_o` bit 5 equals the flag and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tip_i | input | 1 | Slicer output, high during the sync tip |
| amp_ok_i | input | 1 | Sync amplitude above the minimum threshold |
| sync_flag_o | output | 1 | 1 while sync is judged present |
| status_o | output | 8 | Status byte, sync flag in bit 5 |

## Verification
The hardest situation to reach from the ports is the exact end of the hold window, where middling lines and good lines are mixed into a run of loss events. The stimulus builds this case directly. It sends ten bad lines, then five middling lines that must not advance the count, then three more bad lines, and checks that the flag is still 1. A good line then clears the count, and a fresh run of thirteen low-amplitude lines followed by a fourteenth shows exactly where the flag drops. The lost-signal case is reached by stopping all edges after one last line and sampling the flag half a miss period before and half a miss period after the fourteenth missed line.

// File: rtl/sps_pkg.sv
package sps_pkg;

    typedef enum logic [1:0] {
        LK_INVALID = 2'd0,
        LK_BAD     = 2'd1,
        LK_MID     = 2'd2,
        LK_GOOD    = 2'd3
    } line_kind_e;

    typedef enum logic [1:0] {
        ST_NOSYNC = 2'd0,
        ST_LOCKED = 2'd1,
        ST_HOLD   = 2'd2
    } dec_state_e;

endpackage

// File: rtl/sps_line_meter.sv
module sps_line_meter
    import sps_pkg::*;
#(
    parameter int LINE_CLKS = 7945,
    parameter int HI_PCT    = 91,
    parameter int LO_PCT    = 84
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tip_i,
    input  logic       amp_ok_i,
    output logic       rise_o,
    output logic       ev_valid_o,
    output line_kind_e ev_kind_o
);
    localparam int MIN_P   = LINE_CLKS / 2;
    localparam int MAX_P   = 2 * LINE_CLKS;
    localparam int CNT_MAX = MAX_P + 1;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int PW      = CW + 7;

    logic          tip_q;
    logic          armed;
    logic          amp_q;
    logic [CW-1:0] per_cnt;
    logic [CW-1:0] syn_cnt;
    logic [CW-1:0] free_cnt;
    logic [PW-1:0] free_x;
    logic [PW-1:0] hi_lim;
    logic [PW-1:0] lo_lim;
    line_kind_e    kind_c;

    assign rise_o = tip_i & ~tip_q;

    // Rate the line that closes at this rising edge
    always_comb begin
        free_cnt = per_cnt - syn_cnt;
        free_x   = PW'(free_cnt) * PW'(100);
        hi_lim   = PW'(per_cnt) * PW'(HI_PCT);
        lo_lim   = PW'(per_cnt) * PW'(LO_PCT);
        if (!amp_q || per_cnt < CW'(MIN_P) || per_cnt > CW'(MAX_P))
            kind_c = LK_INVALID;
        else if (free_x >= hi_lim)
            kind_c = LK_GOOD;
        else if (free_x <= lo_lim)
            kind_c = LK_BAD;
        else
            kind_c = LK_MID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tip_q      <= 1'b0;
            armed      <= 1'b0;
            amp_q      <= 1'b0;
            per_cnt    <= '0;
            syn_cnt    <= '0;
            ev_valid_o <= 1'b0;
            ev_kind_o  <= LK_INVALID;
        end else begin
            tip_q      <= tip_i;
            ev_valid_o <= 1'b0;
            if (rise_o) begin
                per_cnt <= CW'(1);
                syn_cnt <= CW'(1);
                amp_q   <= amp_ok_i;
                armed   <= 1'b1;
                if (armed) begin
                    ev_valid_o <= 1'b1;
                    ev_kind_o  <= kind_c;
                end
            end else if (per_cnt != CW'(CNT_MAX)) begin
                per_cnt <= per_cnt + 1'b1;
                syn_cnt <= syn_cnt + CW'(tip_i);
            end
        end
    end

endmodule

// File: rtl/sps_gap_timer.sv
module sps_gap_timer #(
    parameter int MISS_CLKS = 11917
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    output logic miss_o
);
    localparam int TW = $clog2(MISS_CLKS + 1);

    logic [TW-1:0] tmr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr    <= '0;
            miss_o <= 1'b0;
        end else if (rise_i) begin
            tmr    <= '0;
            miss_o <= 1'b0;
        end else if (tmr == TW'(MISS_CLKS - 1)) begin
            tmr    <= '0;
            miss_o <= 1'b1;
        end else begin
            tmr    <= tmr + 1'b1;
            miss_o <= 1'b0;
        end
    end

endmodule

// File: rtl/sps_decider.sv
module sps_decider
    import sps_pkg::*;
#(
    parameter int HOLD_LINES = 14,
    parameter int HW         = $clog2(HOLD_LINES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_valid_i,
    input  line_kind_e    ev_kind_i,
    input  logic          miss_i,
    output logic          flag_o,
    output logic [HW-1:0] hold_cnt_o
);
    dec_state_e    state;
    dec_state_e    state_n;
    logic [HW-1:0] hold_n;
    logic          good;
    logic          loss;

    assign good = ev_valid_i && (ev_kind_i == LK_GOOD);
    assign loss = miss_i ||
                  (ev_valid_i && (ev_kind_i == LK_BAD || ev_kind_i == LK_INVALID));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_NOSYNC;
            hold_cnt_o <= '0;
        end else begin
            state      <= state_n;
            hold_cnt_o <= hold_n;
        end
    end

    always_comb begin
        state_n = state;
        hold_n  = hold_cnt_o;
        unique case (state)
            ST_NOSYNC: begin
                if (good) state_n = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (loss) begin
                    state_n = ST_HOLD;
                    hold_n  = HW'(1);
                end
            end
            ST_HOLD: begin
                if (good) begin
                    state_n = ST_LOCKED;
                    hold_n  = '0;
                end else if (loss) begin
                    if (hold_cnt_o == HW'(HOLD_LINES - 1)) begin
                        state_n = ST_NOSYNC;
                        hold_n  = '0;
                    end else begin
                        hold_n = hold_cnt_o + 1'b1;
                    end
                end
            end
            default: begin
                state_n = ST_NOSYNC;
                hold_n  = '0;
            end
        endcase
    end

    always_comb begin
        flag_o = (state != ST_NOSYNC);
    end

endmodule

// File: rtl/sync_presence_det.sv
module sync_presence_det
    import sps_pkg::*;
#(
    parameter int LINE_CLKS  = 7945,
    parameter int HOLD_LINES = 14,
    parameter int HI_PCT     = 91,
    parameter int LO_PCT     = 84
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tip_i,
    input  logic       amp_ok_i,
    output logic       sync_flag_o,
    output logic [7:0] status_o
);
    localparam int MISS_CLKS = LINE_CLKS + LINE_CLKS / 2;
    localparam int HW        = $clog2(HOLD_LINES + 1);
    localparam int SYNC_BIT  = 5;

    logic          rise;
    logic          ev_valid;
    line_kind_e    ev_kind;
    logic          miss_ev;
    logic [HW-1:0] hold_cnt;

    sps_line_meter #(
        .LINE_CLKS(LINE_CLKS),
        .HI_PCT   (HI_PCT),
        .LO_PCT   (LO_PCT)
    ) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tip_i     (tip_i),
        .amp_ok_i  (amp_ok_i),
        .rise_o    (rise),
        .ev_valid_o(ev_valid),
        .ev_kind_o (ev_kind)
    );

    sps_gap_timer #(
        .MISS_CLKS(MISS_CLKS)
    ) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .rise_i(rise),
        .miss_o(miss_ev)
    );

    sps_decider #(
        .HOLD_LINES(HOLD_LINES),
        .HW        (HW)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid_i(ev_valid),
        .ev_kind_i (ev_kind),
        .miss_i    (miss_ev),
        .flag_o    (sync_flag_o),
        .hold_cnt_o(hold_cnt)
    );

    always_comb begin
        status_o           = '0;
        status_o[SYNC_BIT] = sync_flag_o;
    end

endmodule

// File: rtl/sps_checker.sv
module sps_checker
    import sps_pkg::*;
#(
    parameter int HOLD_LINES = 14,
    parameter int HW         = $clog2(HOLD_LINES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tip_i,
    input logic          sync_flag_o,
    input logic          ev_valid,
    input line_kind_e    ev_kind,
    input logic          miss_ev,
    input logic [HW-1:0] hold_cnt
);

    p_rise_on_good_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_flag_o) |-> $past(ev_valid && ev_kind == LK_GOOD));

    p_quiet_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sync_flag_o) |-> $past(ev_valid || miss_ev));

    p_event_after_tip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> $past(tip_i));

    p_fall_on_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_flag_o) |-> $past(miss_ev ||
            (ev_valid && (ev_kind == LK_BAD || ev_kind == LK_INVALID))));

    p_hold_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt < HW'(HOLD_LINES));

endmodule

bind sync_presence_det sps_checker #(
    .HOLD_LINES(HOLD_LINES),
    .HW        (HW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tip_i      (tip_i),
    .sync_flag_o(sync_flag_o),
    .ev_valid   (ev_valid),
    .ev_kind    (ev_kind),
    .miss_ev    (miss_ev),
    .hold_cnt   (hold_cnt)
);

// File: tb/sync_presence_det_test.sv
module sync_presence_det_test;

    localparam int LINE = 100;
    localparam int MISS = LINE + LINE / 2;

    typedef struct {
        logic  flag;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tip_i = 1'b0;
    logic       amp_ok_i = 1'b0;
    logic       sync_flag_o;
    logic [7:0] status_o;

    int   total = 0;
    int   bad = 0;
    exp_t exp_q[$];
    event line_start;

    always #4 clk = ~clk;

    sync_presence_det #(.LINE_CLKS(LINE)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tip_i      (tip_i),
        .amp_ok_i   (amp_ok_i),
        .sync_flag_o(sync_flag_o),
        .status_o   (status_o)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one line starting at the current negedge; queues the rating outcome
    task automatic line(input int syn, input int len, input bit amp, input bit exp, input string tag);
        exp_t e;
        tip_i    = 1'b1;
        amp_ok_i = amp;
        -> line_start;
        repeat (syn) @(negedge clk);
        tip_i = 1'b0;
        repeat (len - syn) @(negedge clk);
        e.flag = exp;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: the closing edge of a line is the next line's start
    initial begin
        forever begin
            @(line_start);
            repeat (4) @(posedge clk);
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({7'b0, sync_flag_o}, {7'b0, e.flag}, e.tag);
                check(status_o, {2'b00, e.flag, 5'b00000}, "R9 status byte");
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({7'b0, sync_flag_o}, 8'h00, "R1 flag in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({7'b0, sync_flag_o}, 8'h00, "R1 flag after reset");
        check(status_o, 8'h00, "R1 status after reset");

        line(12, LINE, 1, 0, "R4 middling line from NOSYNC");
        line(16, LINE, 1, 0, "R3 84% bad line from NOSYNC");
        line(9,  LINE, 1, 1, "R2 91% boundary good line");
        line(12, LINE, 1, 1, "R4 middling keeps lock");
        line(10, LINE, 1, 1, "R4 90% keeps lock");

        for (int i = 0; i < 13; i++) line(16, LINE, 1, 1, "R7 hold through bad lines");
        line(16, LINE, 1, 0, "R7 fourteenth bad line drops");

        line(7, LINE, 0, 0, "R5 low amplitude good duty ignored");
        line(2, 49,   1, 0, "R6 short period invalid");
        line(7, 201,  1, 0, "R6 long period invalid");
        line(2, 50,   1, 1, "R6 lower period limit valid");
        line(7, 200,  1, 1, "R6 upper period limit valid");

        for (int i = 0; i < 10; i++) line(16, LINE, 1, 1, "R7 bad lines in hold");
        for (int i = 0; i < 5; i++)  line(12, LINE, 1, 1, "R4 middling does not advance hold");
        for (int i = 0; i < 3; i++)  line(16, LINE, 1, 1, "R4 hold count 13 after middling");
        line(7, LINE, 1, 1, "R7 good line restores lock");
        for (int i = 0; i < 13; i++) line(7, LINE, 0, 1, "R5 low amplitude is loss");
        line(7, LINE, 0, 0, "R5 fourteenth invalid line drops");
        line(7, LINE, 1, 1, "R2 relock");

        // Final edge, then no more edges
        tip_i    = 1'b1;
        amp_ok_i = 1'b1;
        -> line_start;
        repeat (7) @(negedge clk);
        tip_i = 1'b0;
        repeat (13 * MISS + MISS / 2 - 7) @(negedge clk);
        check({7'b0, sync_flag_o}, 8'h01, "R8 flag held after 13 missed lines");
        check(status_o, 8'h20, "R9 status bit 5 set");
        repeat (MISS) @(negedge clk);
        check({7'b0, sync_flag_o}, 8'h00, "R8 flag clear after 14 missed lines");
        check(status_o, 8'h00, "R9 status cleared");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule